// File: doc/BRIEF.md
# Multi-Block ChaCha Stream XOR Engine

This block encrypts or decrypts a message of up to five consecutive ChaCha blocks (320 bytes) from one 512-bit base state. A single `start` pulse captures the base state and a byte count. The engine then derives block *i*'s state from the base by adding *i* to state word 12. It runs each block through one shared iterative block core, one round per clock. It XORs the resulting keystream with message data that arrives in 32-bit beats over a valid/ready input.

Each accepted input beat yields exactly one registered output beat on the following clock. That beat carries a byte-enable mask, so the consumer can tell which bytes belong to the message. The final beat of a message carries a last flag and only as many enabled bytes as remain in the message. Disabled bytes are driven to zero. The `done` output pulses together with the last beat, or alone one cycle after `start` when the byte count is zero. Key/nonce setup and carry from word 12 into word 13 are handled outside this block.

Top module: `chacha_multi_xor`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `out_last` and `done` are 0.
- R2: Block *i* (i = 0..4) of a message uses state word 12 equal to the base word 12 plus *i*, modulo 2^32. Word 13 is never changed. That same incremented value is the one added back in the feed-forward step.
- R3: Message beat *b* covers bytes 4b..4b+3, with byte k of a beat in bits [8k+7:8k]. It is XORed with keystream word (b mod 16) of block b/16. Each keystream word is the permuted state word plus the block's own input state word, mod 2^32. Blocks come out in increasing counter order.
- R4: The permutation is the standard ChaCha block function with 10 double rounds, where each double round is a column round on (0,4,8,12)…(3,7,11,15) followed by a diagonal round on (0,5,10,15),(1,6,11,12),(2,7,8,13),(3,4,9,14). Quarter-round rotates are 16, 12, 8 and 7.
- R5: `out_keep` bit k marks byte k of the beat as a message byte. Every beat but the last has `out_keep` = 4'hF. The last beat has the low (remaining bytes) bits set. Bytes whose keep bit is 0 read as zero.
- R6: A message of n bytes produces exactly ceil(n/4) output beats. `out_last` is 1 on the final beat only.
- R7: A byte count of zero produces no output beat and pulses `done` in the cycle after `start` is sampled.
- R8: A byte count above 320 is processed as 320.
- R9: `done` is a single-cycle pulse coinciding with the last output beat of a nonzero-length message.
- R10: `start` is ignored while a message is in progress.
- R11: `in_ready` is 0 while a block's keystream is being generated. An output beat appears exactly one cycle after each input handshake and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message (sampled only when idle) |
| base_state | input | 512 | Base state, word j in bits [32j+31:32j], word 12 is the block counter |
| byte_count | input | 9 | Message length in bytes, clamped to 320 |
| in_valid | input | 1 | Input beat present |
| in_data | input | 32 | Input message bytes, byte k in bits [8k+7:8k] |
| in_ready | output | 1 | Engine accepts an input beat this cycle |
| out_valid | output | 1 | Output beat present |
| out_data | output | 32 | Input XOR keystream, disabled bytes zero |
| out_keep | output | 4 | Byte enables for out_data |
| out_last | output | 1 | Final beat of the message |
| done | output | 1 | Message complete pulse |

## Verification
The bench targets lengths on block and beat boundaries: 0, 1, 63, 64, 65, 128, 256 and 320 bytes, plus lengths past the limit. An engine that mishandles the partial tail would either emit an extra all-enabled beat or leak keystream in trimmed bytes. One that treats an exact multiple of 64 as partial would start a sixth block or hang. A base counter of 0xFFFFFFFE forces word 12 to wrap mid-message, which exposes a counter that carries into word 13 or a feed-forward that adds back the base counter instead of the block's own. A known-answer block pins the round order and rotate amounts. A stray `start` pulse injected during generation must leave the stream untouched.

// File: rtl/chacha_mx_pkg.sv
package chacha_mx_pkg;

    typedef logic [31:0] word_t;
    typedef word_t [15:0] blk_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LAUNCH,
        PH_WAIT,
        PH_STREAM
    } phase_e;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic quad_t quarter(input quad_t q);
        quad_t r;
        r = q;
        r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 16);
        r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 12);
        r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 8);
        r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 7);
        return r;
    endfunction

endpackage

// File: rtl/chacha_round.sv
module chacha_round
    import chacha_mx_pkg::*;
#(
    parameter int DIAG = 0
) (
    input  blk_t s_i,
    output blk_t s_o
);
    quad_t res [4];

    for (genvar q = 0; q < 4; q++) begin : g_qr
        localparam int IA = q;
        localparam int IB = 4 + ((q + DIAG) % 4);
        localparam int IC = 8 + ((q + 2 * DIAG) % 4);
        localparam int ID = 12 + ((q + 3 * DIAG) % 4);
        assign res[q] = quarter({s_i[IA], s_i[IB], s_i[IC], s_i[ID]});
    end

    always_comb begin
        s_o = s_i;
        for (int q = 0; q < 4; q++) begin
            s_o[q]                          = res[q].a;
            s_o[4 + ((q + DIAG) % 4)]       = res[q].b;
            s_o[8 + ((q + 2 * DIAG) % 4)]   = res[q].c;
            s_o[12 + ((q + 3 * DIAG) % 4)]  = res[q].d;
        end
    end
endmodule

// File: rtl/chacha_core.sv
module chacha_core
    import chacha_mx_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  blk_t init_i,
    output logic done_o,
    output blk_t ks_o
);
    localparam int NROUNDS = 2 * DOUBLE_ROUNDS;
    localparam int RC_W    = $clog2(NROUNDS);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [RC_W-1:0] cnt;
        blk_t            work;
        blk_t            init;
    } core_reg_t;

    core_reg_t q, d;
    blk_t      rnd_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_rnd
        chacha_round #(.DIAG(g)) u_round (
            .s_i (q.work),
            .s_o (rnd_out[g])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.work = init_i;
            d.init = init_i;
            d.cnt  = '0;
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.work = rnd_out[q.cnt[0]];
            if (q.cnt == RC_W'(NROUNDS - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar j = 0; j < 16; j++) begin : g_ff
        assign ks_o[j] = q.work[j] + q.init[j];
    end

    assign done_o = q.done;
endmodule

// File: rtl/chacha_beat.sv
module chacha_beat
    import chacha_mx_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] rem_i,
    input  word_t            data_i,
    input  word_t            ks_i,
    output word_t            data_o,
    output logic [3:0]       keep_o,
    output logic             last_o
);
    for (genvar k = 0; k < 4; k++) begin : g_byte
        assign keep_o[k]       = rem_i > CNT_W'(k);
        assign data_o[8*k +: 8] = keep_o[k] ? (data_i[8*k +: 8] ^ ks_i[8*k +: 8]) : 8'h00;
    end

    assign last_o = rem_i <= CNT_W'(4);
endmodule

// File: rtl/chacha_multi_xor.sv
module chacha_multi_xor
    import chacha_mx_pkg::*;
#(
    parameter int MAX_BLOCKS    = 5,
    parameter int DOUBLE_ROUNDS = 10,
    localparam int MAX_BYTES    = MAX_BLOCKS * 64,
    localparam int CNT_W        = $clog2(MAX_BYTES + 1),
    localparam int BLK_W        = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [511:0]     base_state,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic [3:0]       out_keep,
    output logic             out_last,
    output logic             done
);
    typedef struct packed {
        phase_e           phase;
        logic [BLK_W-1:0] blk;
        logic [3:0]       word;
        logic [CNT_W-1:0] rem;
        blk_t             base;
        logic             out_valid;
        logic             out_last;
        logic [3:0]       out_keep;
        word_t            out_data;
        logic             done;
    } top_reg_t;

    top_reg_t         q, d;
    logic             core_start, core_done;
    blk_t             core_init, core_ks;
    word_t            beat_data;
    logic [3:0]       beat_keep;
    logic             beat_last;
    logic [CNT_W-1:0] eff_count;

    chacha_core #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (core_start),
        .init_i  (core_init),
        .done_o  (core_done),
        .ks_o    (core_ks)
    );

    chacha_beat #(.CNT_W(CNT_W)) u_beat (
        .rem_i  (q.rem),
        .data_i (in_data),
        .ks_i   (core_ks[q.word]),
        .data_o (beat_data),
        .keep_o (beat_keep),
        .last_o (beat_last)
    );

    assign eff_count = (byte_count > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byte_count;

    always_comb begin
        core_init     = q.base;
        core_init[12] = q.base[12] + {{(32-BLK_W){1'b0}}, q.blk};
    end

    always_comb begin
        d            = q;
        d.out_valid  = 1'b0;
        d.out_last   = 1'b0;
        d.out_keep   = '0;
        d.out_data   = '0;
        d.done       = 1'b0;
        core_start   = 1'b0;
        in_ready     = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (eff_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.phase = PH_LAUNCH;
                        d.base  = blk_t'(base_state);
                        d.rem   = eff_count;
                        d.blk   = '0;
                        d.word  = '0;
                    end
                end
            end
            PH_LAUNCH: begin
                core_start = 1'b1;
                d.phase    = PH_WAIT;
            end
            PH_WAIT: begin
                if (core_done) d.phase = PH_STREAM;
            end
            PH_STREAM: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.out_valid = 1'b1;
                    d.out_data  = beat_data;
                    d.out_keep  = beat_keep;
                    d.out_last  = beat_last;
                    if (beat_last) begin
                        d.rem   = '0;
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.rem = q.rem - CNT_W'(4);
                        if (q.word == 4'd15) begin
                            d.word  = '0;
                            d.blk   = q.blk + 1'b1;
                            d.phase = PH_LAUNCH;
                        end else begin
                            d.word = q.word + 1'b1;
                        end
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.out_valid;
    assign out_data  = q.out_data;
    assign out_keep  = q.out_keep;
    assign out_last  = q.out_last;
    assign done      = q.done;
endmodule

// File: rtl/chacha_multi_xor_chk.sv
module chacha_multi_xor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic [3:0]  out_keep,
    input logic        out_last,
    input logic        done
);
    logic [31:0] keep_mask;
    assign keep_mask = {{8{out_keep[3]}}, {8{out_keep[2]}}, {8{out_keep[1]}}, {8{out_keep[0]}}};

    assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_keep_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_keep == 4'h1 || out_keep == 4'h3 || out_keep == 4'h7 || out_keep == 4'hF));

    assert_keep_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> out_keep == 4'hF);

    assert_trim_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data & ~keep_mask) == 32'h0);

    assert_done_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_beat_follows_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_no_spurious_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_valid && in_ready)) |-> 1'b0);
endmodule

bind chacha_multi_xor chacha_multi_xor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last),
    .done      (done)
);

// File: tb/chacha_multi_xor_tb_top.sv
module chacha_multi_xor_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] base_state = '0;
    logic [8:0]   byte_count = '0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_data = '0;
    logic         in_ready, out_valid, out_last, done;
    logic [31:0]  out_data;
    logic [3:0]   out_keep;

    int checks = 0;
    int fails  = 0;

    logic [31:0] in_words [80];
    logic [31:0] exp_ks   [80];
    logic [31:0] cap      [80];

    always #10 clk = ~clk;

    chacha_multi_xor dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_state(base_state),
        .byte_count(byte_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last), .done(done)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] bqr(input logic [31:0] a, b, c, d);
        a += b; d = rl(d ^ a, 16);
        c += d; b = rl(b ^ c, 12);
        a += b; d = rl(d ^ a, 8);
        c += d; b = rl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] ref_block(input logic [511:0] st, input logic [31:0] ctr);
        logic [31:0] s [16];
        logic [31:0] x [16];
        logic [511:0] r;
        for (int j = 0; j < 16; j++) s[j] = st[32*j +: 32];
        s[12] = ctr;
        for (int j = 0; j < 16; j++) x[j] = s[j];
        for (int i = 0; i < 10; i++) begin
            {x[0], x[4], x[8],  x[12]} = bqr(x[0], x[4], x[8],  x[12]);
            {x[1], x[5], x[9],  x[13]} = bqr(x[1], x[5], x[9],  x[13]);
            {x[2], x[6], x[10], x[14]} = bqr(x[2], x[6], x[10], x[14]);
            {x[3], x[7], x[11], x[15]} = bqr(x[3], x[7], x[11], x[15]);
            {x[0], x[5], x[10], x[15]} = bqr(x[0], x[5], x[10], x[15]);
            {x[1], x[6], x[11], x[12]} = bqr(x[1], x[6], x[11], x[12]);
            {x[2], x[7], x[8],  x[13]} = bqr(x[2], x[7], x[8],  x[13]);
            {x[3], x[4], x[9],  x[14]} = bqr(x[3], x[4], x[9],  x[14]);
        end
        for (int j = 0; j < 16; j++) r[32*j +: 32] = x[j] + s[j];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] rand_state();
        logic [511:0] s;
        for (int j = 0; j < 16; j++) s[32*j +: 32] = $urandom;
        return s;
    endfunction

    task automatic run_req(input logic [511:0] base, input int cnt, input bit zero_in, input bit stray);
        int eff, nbeats, ib, ob, cyc;
        bit seen_done;
        logic [511:0] blkv;
        eff    = (cnt > 320) ? 320 : cnt;
        nbeats = (eff + 3) / 4;
        for (int b = 0; b < 5; b++) begin
            blkv = ref_block(base, base[415:384] + 32'(b));
            for (int w = 0; w < 16; w++) exp_ks[16*b + w] = blkv[32*w +: 32];
        end
        for (int i = 0; i < 80; i++) in_words[i] = zero_in ? 32'h0 : $urandom;
        @(negedge clk);
        start = 1'b1; base_state = base; byte_count = 9'(cnt);
        @(negedge clk);
        start = 1'b0;
        chk(in_ready == 1'b0, "R11", 64'(in_ready), 64'h0);
        ib = 0; ob = 0; seen_done = 0; cyc = 0;
        while (!seen_done && cyc < 3000) begin
            if (out_valid) begin
                int rem;
                logic [3:0]  ek;
                logic [31:0] m, ed;
                rem = eff - 4 * ob;
                ek  = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
                m   = {{8{ek[3]}}, {8{ek[2]}}, {8{ek[1]}}, {8{ek[0]}}};
                ed  = (in_words[ob] ^ exp_ks[ob]) & m;
                if (ob < 80) cap[ob] = out_data;
                chk(out_data == ed, (ob >= 16) ? "R2" : "R3", 64'(out_data), 64'(ed));
                chk(out_keep == ek, "R5", 64'(out_keep), 64'(ek));
                chk(out_last == (ob == nbeats - 1), "R6", 64'(out_last), 64'(ob == nbeats - 1));
                ob++;
            end
            if (done) begin
                seen_done = 1;
                if (eff == 0) chk(cyc == 0, "R7", 64'(cyc), 64'h0);
                else          chk(out_valid && out_last, "R9", 64'(out_last), 64'h1);
            end
            if (stray && cyc == 5) begin
                start = 1'b1; base_state = rand_state(); byte_count = 9'd7;
            end else begin
                start = 1'b0;
            end
            in_valid = (ib < nbeats) && ($urandom % 4 != 0);
            in_data  = (ib < 80) ? in_words[ib] : 32'h0;
            if (in_valid && in_ready) ib++;
            cyc++;
            if (!seen_done) @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b0;
        chk(seen_done, "R9", 64'(seen_done), 64'h1);
        chk(ob == nbeats, (cnt > 320) ? "R8" : "R6", 64'(ob), 64'(nbeats));
        @(negedge clk);
        chk(!out_valid && !done, "R9", {62'h0, out_valid, done}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [511:0] kat;
        void'($urandom(32'h5eed_c4a7));
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !in_ready && !out_last, "R1",
            {60'h0, out_valid, done, in_ready, out_last}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done && !in_ready, "R1", {61'h0, out_valid, done, in_ready}, 64'h0);

        kat = '0;
        kat[31:0]    = 32'h61707865; kat[63:32]   = 32'h3320646e;
        kat[95:64]   = 32'h79622d32; kat[127:96]  = 32'h6b206574;
        for (int j = 0; j < 8; j++)
            kat[128 + 32*j +: 32] = {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)};
        kat[415:384] = 32'h00000001; kat[447:416] = 32'h09000000;
        kat[479:448] = 32'h4a000000; kat[511:480] = 32'h00000000;
        run_req(kat, 64, 1'b1, 1'b0);
        chk(cap[0] == 32'he4e7f110, "R4", 64'(cap[0]), 64'he4e7f110);
        chk(cap[1] == 32'h15593bd1, "R4", 64'(cap[1]), 64'h15593bd1);
        chk(cap[2] == 32'h1fdd0f50, "R4", 64'(cap[2]), 64'h1fdd0f50);
        chk(cap[3] == 32'hc47120a3, "R4", 64'(cap[3]), 64'hc47120a3);

        run_req(rand_state(), 0, 1'b0, 1'b0);    // R7
        run_req(rand_state(), 1, 1'b0, 1'b0);    // R5
        run_req(rand_state(), 63, 1'b0, 1'b0);
        run_req(rand_state(), 65, 1'b0, 1'b0);
        run_req(rand_state(), 128, 1'b0, 1'b1);  // R10 stray start
        run_req(rand_state(), 256, 1'b0, 1'b0);
        run_req(rand_state(), 320, 1'b0, 1'b0);
        run_req(rand_state(), 400, 1'b0, 1'b0);  // R8
        begin
            logic [511:0] w;
            w = rand_state();
            w[415:384] = 32'hFFFFFFFE;            // R2 wrap
            run_req(w, 320, 1'b0, 1'b0);
        end
        for (int t = 0; t < 12; t++)
            run_req(rand_state(), int'($urandom % 331), 1'b0, (t % 3) == 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule